// File: doc/BRIEF.md
# Sensor SPI Master with Inter-Frame Stall Timing

This block is a bus master for a sensor-style peripheral on a four-wire serial link. Each command from a valid/ready port becomes one 16-bit full-duplex frame. The clock idles high. The master changes its data output on falling clock edges, and both ends sample on rising clock edges. The head of every frame carries a direction flag, a zero pad bit and a six-bit register address. A write carries its data byte in the low half of the frame; a read sends zeros there.

The peripheral answers a read one frame late. The word the master shifts in during the frame after a read is therefore handed out as that read's response. Frames that follow a write produce no response.

The mode comes from an eight-bit sample-period input and is taken when a command is accepted. A value of eight or more selects low-power timing; anything below selects normal timing. The mode sets the serial clock half-period, the shortest chip-select high time after the frame, and the shortest start-to-start spacing before the next frame. Every cycle count is worked out from a system clock frequency parameter and rounded up, so no minimum is ever cut short.

Top module: `spiStallMaster`

## Requirements
- R1: After reset, csN and sclk are high, cmdReady is high and rspValid is low.
- R2: The frame on din is sent MSB first. Bit 15 is 1 for a write and 0 for a read, bit 14 is 0, bits 13:8 hold the address, and bits 7:0 hold the write data (zero for a read). din changes only when csN falls or sclk falls.
- R3: Each frame has exactly 16 rising sclk edges. Every sclk half-period between edges of a frame lasts exactly the mode's half-period count: ceil of 200 ns in normal mode and ceil of 500 ns in low-power mode. sclk never toggles while csN is high.
- R4: Low-power mode is used when sampPeriod is 8 or more, and normal mode otherwise. The mode is taken at command acceptance, and a change of sampPeriod during a frame does not alter that frame.
- R5: The first sclk falling edge comes exactly ceil(48.8 ns) cycles after csN falls. csN rises exactly ceil(5 ns) cycles after the last rising sclk edge (at least one cycle in both cases).
- R6: After a frame, csN stays high for at least ceil(9 us) cycles in normal mode and ceil(12 us) in low-power mode, using the mode of the frame just ended.
- R7: From one csN fall to the next there are at least ceil(32 us) cycles in normal mode and ceil(42 us) in low-power mode, using the mode of the earlier frame. When a command is already waiting, the next frame starts on the first cycle that both limits allow.
- R8: cmdReady is low while csN is low and until both the stall and the period limits have expired. No frame starts without cmdValid.
- R9: After a read, rspValid pulses for one cycle as csN rises at the end of the next frame. rspData then holds the 16 dout bits sampled on that frame's rising sclk edges, MSB first.
- R10: A frame following a write produces no response, so the number of responses equals the number of reads that were followed by a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sampPeriod | input | 8 | Sample-period value selecting the mode |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command may be accepted this cycle |
| cmdWrite | input | 1 | 1 for a write, 0 for a read |
| cmdAddr | input | 6 | Register address |
| cmdData | input | 8 | Write data |
| rspValid | output | 1 | Response strobe |
| rspData | output | 16 | Word received in the frame after a read |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data to the peripheral |
| dout | input | 1 | Serial data from the peripheral |

## Verification
Writes to a group of addresses are followed by reads of all 64 addresses in normal mode. The peripheral model returns the address in each reply, so the bench can tell a misordered or shifted address field from a wrong data byte or a lost response. Low-power frames run with sampPeriod at 8 and at 255, and normal frames run with it at 0 and 7, so both sides of the threshold give the half-period and the gap lengths. One frame has its sampPeriod changed while it is in flight; this separates taking the mode at acceptance from tracking it continuously. Back-to-back commands show whether the next frame starts on the exact cycle the period limit ends, and an idle stretch with no request shows that no frame starts on its own.

// File: rtl/spiStallPkg.sv
package spiStallPkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // command accepted: load frame, drop chip select
    logic fall;   // drive sclk low and present next din bit
    logic rise;   // drive sclk high and sample dout
    logic done;   // raise chip select, publish response
  } strobeT;

  // Cycles needed to cover a time given in tenths of ns, rounded up, at least 1
  function automatic int cyclesFor(input longint tenthsNs, input longint clkHz);
    longint q;
    q = (tenthsNs * clkHz + 64'd9999999999) / 64'd10000000000;
    return (q < 1) ? 1 : int'(q);
  endfunction

endpackage

// File: rtl/spiStallCtrl.sv
module spiStallCtrl
  import spiStallPkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int HALF_N     = 4,
  parameter int HALF_L     = 10,
  parameter int SETUP_CYC  = 1,
  parameter int HOLD_CYC   = 1,
  parameter int STALL_N    = 180,
  parameter int STALL_L    = 240,
  parameter int PERIOD_N   = 640,
  parameter int PERIOD_L   = 840
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cmdValid,
  input  logic   lowPowerReq,
  output logic   cmdReady,
  output strobeT strobe
);

  localparam int PH_MAX  = (HALF_L > HALF_N) ? HALF_L : HALF_N;
  localparam int PH_MAX2 = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CNT_W   = $clog2(((PH_MAX > PH_MAX2) ? PH_MAX : PH_MAX2) + 1);
  localparam int T_MAX1  = (PERIOD_L > PERIOD_N) ? PERIOD_L : PERIOD_N;
  localparam int T_MAX2  = (STALL_L > STALL_N) ? STALL_L : STALL_N;
  localparam int TMR_W   = $clog2(((T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2) + 1);
  localparam int BIT_W   = $clog2(FRAME_BITS + 1);

  typedef enum logic [2:0] {sIdle, sSetup, sLow, sHigh, sHold} stateT;

  stateT             state;
  logic [CNT_W-1:0]  phaseCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [TMR_W-1:0]  periodCnt;
  logic [TMR_W-1:0]  stallCnt;
  logic              lpFrame;
  logic [CNT_W-1:0]  halfCyc;
  logic              accept;
  logic              phaseEnd;

  assign halfCyc  = lpFrame ? CNT_W'(HALF_L - 1) : CNT_W'(HALF_N - 1);
  assign cmdReady = (state == sIdle) && (periodCnt == '0) && (stallCnt == '0);
  assign accept   = cmdValid && cmdReady;
  assign phaseEnd = (phaseCnt == '0);

  always_comb begin
    strobe = '0;
    unique case (state)
      sIdle:  strobe.load = accept;
      sSetup: strobe.fall = phaseEnd;
      sLow:   strobe.rise = phaseEnd;
      sHigh:  strobe.fall = phaseEnd;
      sHold:  strobe.done = phaseEnd;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= sIdle;
      phaseCnt  <= '0;
      bitCnt    <= '0;
      periodCnt <= '0;
      stallCnt  <= '0;
      lpFrame   <= 1'b0;
    end else begin
      if (accept)
        periodCnt <= lowPowerReq ? TMR_W'(PERIOD_L - 1) : TMR_W'(PERIOD_N - 1);
      else if (periodCnt != '0)
        periodCnt <= periodCnt - 1'b1;

      if (strobe.done)
        stallCnt <= lpFrame ? TMR_W'(STALL_L - 1) : TMR_W'(STALL_N - 1);
      else if (stallCnt != '0)
        stallCnt <= stallCnt - 1'b1;

      unique case (state)
        sIdle: if (accept) begin
          state    <= sSetup;
          phaseCnt <= CNT_W'(SETUP_CYC - 1);
          bitCnt   <= '0;
          lpFrame  <= lowPowerReq;
        end
        sSetup: if (phaseEnd) begin
          state    <= sLow;
          phaseCnt <= halfCyc;
        end else phaseCnt <= phaseCnt - 1'b1;
        sLow: if (phaseEnd) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BIT_W'(FRAME_BITS - 1)) begin
            state    <= sHold;
            phaseCnt <= CNT_W'(HOLD_CYC - 1);
          end else begin
            state    <= sHigh;
            phaseCnt <= halfCyc;
          end
        end else phaseCnt <= phaseCnt - 1'b1;
        sHigh: if (phaseEnd) begin
          state    <= sLow;
          phaseCnt <= halfCyc;
        end else phaseCnt <= phaseCnt - 1'b1;
        sHold: if (phaseEnd) state <= sIdle;
               else phaseCnt <= phaseCnt - 1'b1;
        default: state <= sIdle;
      endcase
    end
  end

endmodule

// File: rtl/spiStallDatapath.sv
module spiStallDatapath
  import spiStallPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobeT                     strobe,
  input  logic                       cmdWrite,
  input  logic [ADDR_W-1:0]          cmdAddr,
  input  logic [DATA_W-1:0]          cmdData,
  input  logic                       dout,
  output logic                       csN,
  output logic                       sclk,
  output logic                       din,
  output logic                       rspValid,
  output logic [ADDR_W+DATA_W+1:0]   rspData
);

  localparam int FRAME_BITS = ADDR_W + DATA_W + 2;

  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] rxShift;
  logic [FRAME_BITS-1:0] frameWord;
  logic                  curRead;
  logic                  pendRead;

  // direction flag, zero pad, address, data (zero for a read)
  assign frameWord = {cmdWrite, 1'b0, cmdAddr, (cmdWrite ? cmdData : DATA_W'(0))};

  always_ff @(posedge clk) begin
    if (rst) begin
      csN      <= 1'b1;
      sclk     <= 1'b1;
      din      <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      curRead  <= 1'b0;
      pendRead <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= 1'b0;
      if (strobe.load) begin
        txShift <= frameWord;
        din     <= frameWord[FRAME_BITS-1];
        csN     <= 1'b0;
        curRead <= !cmdWrite;
      end
      if (strobe.fall) begin
        sclk <= 1'b0;
        din  <= txShift[FRAME_BITS-1];
      end
      if (strobe.rise) begin
        sclk    <= 1'b1;
        rxShift <= {rxShift[FRAME_BITS-2:0], dout};
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (strobe.done) begin
        csN      <= 1'b1;
        rspValid <= pendRead;
        rspData  <= rxShift;
        pendRead <= curRead;
      end
    end
  end

endmodule

// File: rtl/spiStallMaster.sv
module spiStallMaster
  import spiStallPkg::*;
#(
  parameter longint CLK_HZ         = 20_000_000,
  parameter int     ADDR_W         = 6,
  parameter int     DATA_W         = 8,
  parameter int     MODE_W         = 8,
  parameter int     LP_THRESH      = 8,
  // time limits in tenths of a nanosecond
  parameter longint HALF_N_T10     = 2000,
  parameter longint HALF_L_T10     = 5000,
  parameter longint SETUP_T10      = 488,
  parameter longint HOLD_T10       = 50,
  parameter longint STALL_N_T10    = 90000,
  parameter longint STALL_L_T10    = 120000,
  parameter longint PERIOD_N_T10   = 320000,
  parameter longint PERIOD_L_T10   = 420000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [MODE_W-1:0]         sampPeriod,
  input  logic                      cmdValid,
  output logic                      cmdReady,
  input  logic                      cmdWrite,
  input  logic [ADDR_W-1:0]         cmdAddr,
  input  logic [DATA_W-1:0]         cmdData,
  output logic                      rspValid,
  output logic [ADDR_W+DATA_W+1:0]  rspData,
  output logic                      csN,
  output logic                      sclk,
  output logic                      din,
  input  logic                      dout
);

  localparam int FRAME_BITS  = ADDR_W + DATA_W + 2;
  localparam int HALF_N_CYC  = cyclesFor(HALF_N_T10, CLK_HZ);
  localparam int HALF_L_CYC  = cyclesFor(HALF_L_T10, CLK_HZ);
  localparam int SETUP_CYC   = cyclesFor(SETUP_T10, CLK_HZ);
  localparam int HOLD_CYC    = cyclesFor(HOLD_T10, CLK_HZ);
  localparam int STALL_N_CYC = cyclesFor(STALL_N_T10, CLK_HZ);
  localparam int STALL_L_CYC = cyclesFor(STALL_L_T10, CLK_HZ);
  localparam int PERIOD_N_CYC = cyclesFor(PERIOD_N_T10, CLK_HZ);
  localparam int PERIOD_L_CYC = cyclesFor(PERIOD_L_T10, CLK_HZ);

  strobeT strobe;
  logic   lowPowerReq;

  assign lowPowerReq = (sampPeriod >= MODE_W'(LP_THRESH));

  spiStallCtrl #(
    .FRAME_BITS(FRAME_BITS),
    .HALF_N(HALF_N_CYC), .HALF_L(HALF_L_CYC),
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .STALL_N(STALL_N_CYC), .STALL_L(STALL_L_CYC),
    .PERIOD_N(PERIOD_N_CYC), .PERIOD_L(PERIOD_L_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .lowPowerReq(lowPowerReq),
    .cmdReady(cmdReady), .strobe(strobe)
  );

  spiStallDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdData(cmdData), .dout(dout),
    .csN(csN), .sclk(sclk), .din(din), .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/spiStallChk.sv
module spiStallChk #(
  parameter int STALL_MIN = 180
) (
  input logic clk,
  input logic rst,
  input logic csN,
  input logic sclk,
  input logic din,
  input logic cmdReady,
  input logic rspValid
);

  logic [31:0] highCnt;
  logic        seenFrame;

  always_ff @(posedge clk) begin
    if (rst) begin
      highCnt   <= '0;
      seenFrame <= 1'b0;
    end else begin
      if (!csN) begin
        highCnt   <= '0;
        seenFrame <= 1'b1;
      end else if (highCnt != 32'hFFFF_FFFF) begin
        highCnt <= highCnt + 1'b1;
      end
    end
  end

  // R1: clock stays idle high whenever chip select is high
  p_idle_clock_r1: assert property (@(posedge clk) disable iff (rst) csN |-> sclk);

  // R8: no new command while a frame is on the bus
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst) !csN |-> !cmdReady);

  // R2: data line moves only with a clock fall or chip select fall
  p_din_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(din) |-> ($fell(sclk) || $fell(csN)));

  // R9: response is a single-cycle pulse
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst) rspValid |=> !rspValid);

  // R9: response appears exactly when a frame ends
  p_rsp_at_end_r9: assert property (@(posedge clk) disable iff (rst) rspValid |-> $rose(csN));

  // R6: chip select high time between frames meets the shorter stall
  p_stall_min_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(csN) && seenFrame) |-> (highCnt >= 32'(STALL_MIN)));

endmodule

bind spiStallMaster spiStallChk #(.STALL_MIN(STALL_N_CYC)) u_chk (
  .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .din(din),
  .cmdReady(cmdReady), .rspValid(rspValid)
);

// File: tb/spiStallMaster_bench.sv
module spiStallMaster_bench;

  localparam int     CLK_PERIOD = 50;           // ns
  localparam longint CLK_HZ     = 20_000_000;

  function automatic int ceilDiv(input longint a, input longint b);
    return int'((a + b - 1) / b);
  endfunction

  // Expected cycle counts straight from the requirement times
  localparam int E_HALF_N = ceilDiv(200 * CLK_HZ, 1_000_000_000);
  localparam int E_HALF_L = ceilDiv(500 * CLK_HZ, 1_000_000_000);
  localparam int E_SETUP  = ceilDiv(488 * CLK_HZ, 64'd10_000_000_000);
  localparam int E_HOLD   = ceilDiv(5 * CLK_HZ, 1_000_000_000);
  localparam int E_STALL_N = ceilDiv(9000 * CLK_HZ, 1_000_000_000);
  localparam int E_STALL_L = ceilDiv(12000 * CLK_HZ, 1_000_000_000);
  localparam int E_PER_N  = ceilDiv(32000 * CLK_HZ, 1_000_000_000);
  localparam int E_PER_L  = ceilDiv(42000 * CLK_HZ, 1_000_000_000);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sampPeriod = 8'd7;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic        cmdWrite = 1'b0;
  logic [5:0]  cmdAddr = '0;
  logic [7:0]  cmdData = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        csN, sclk, din;
  logic        dout = 1'b1;

  spiStallMaster #(.CLK_HZ(CLK_HZ)) u_spiStallMaster (
    .clk(clk), .rst(rst), .sampPeriod(sampPeriod),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData),
    .csN(csN), .sclk(sclk), .din(din), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- peripheral model ----------------
  logic [7:0]  pRegs [64];
  logic [15:0] pNext = 16'h0F0F;
  logic [15:0] pWord;
  logic [15:0] pRx;
  int          pFall;
  int          pBits;
  logic [15:0] expDin [$];

  initial for (int i = 0; i < 64; i++) pRegs[i] = 8'(i) ^ 8'h5A;

  always @(negedge csN) begin
    pWord = pNext;
    dout  = pWord[15];
    pFall = 0;
    pBits = 0;
    pRx   = '0;
  end
  always @(negedge sclk) if (!csN) begin
    if (pFall > 0 && pFall < 16) dout = pWord[15 - pFall];
    pFall++;
  end
  always @(posedge sclk) if (!csN) begin
    pRx = {pRx[14:0], din};
    pBits++;
  end
  always @(posedge csN) if (!rst) begin
    logic [15:0] e;
    e = (expDin.size() > 0) ? expDin.pop_front() : 16'hDEAD;
    check(pRx == e, "R2 din frame", pRx, e);
    if (pRx[15]) begin
      pRegs[pRx[13:8]] = pRx[7:0];
      pNext = 16'h0F0F;
    end else begin
      pNext = {pRx[13:8], 2'b01, pRegs[pRx[13:8]]};
    end
    dout = 1'b1;
  end

  // ---------------- timing monitor ----------------
  int  cyc = 0;
  bit  prevCs = 1, prevSclk = 1;
  int  frames = 0, rises = 0, edges = 0;
  int  csFallCyc = 0, csRiseCyc = 0, lastEdgeCyc = 0, lastRiseCyc = 0, frameLen = 0;
  bit  curLp = 0, prevLp = 0, issueLp = 0, issueWaited = 0;
  int  minHalf = 0, maxHalf = 0, lastMinHalf = 0, lastMaxHalf = 0;
  logic [15:0] expRsp [$];
  int  rspCount = 0, rspExpected = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prevCs && !csN) begin
        frames++;
        if (frames > 1) begin
          int st, per, exact;
          st  = cyc - csRiseCyc;
          per = cyc - csFallCyc;
          check(st >= (prevLp ? E_STALL_L : E_STALL_N), "R6 stall", st, prevLp ? E_STALL_L : E_STALL_N);
          check(per >= (prevLp ? E_PER_L : E_PER_N), "R7 period", per, prevLp ? E_PER_L : E_PER_N);
          if (issueWaited) begin
            exact = prevLp ? E_PER_L : E_PER_N;
            if (frameLen + (prevLp ? E_STALL_L : E_STALL_N) > exact)
              exact = frameLen + (prevLp ? E_STALL_L : E_STALL_N);
            check(per == exact, "R7 exact restart", per, exact);
          end
        end
        csFallCyc = cyc; curLp = issueLp; rises = 0; edges = 0; lastEdgeCyc = cyc;
        minHalf = 1000000; maxHalf = 0;
      end
      if (sclk != prevSclk) begin
        if (csN) check(0, "R3 sclk toggled while idle", 1, 0);
        else if (!sclk && edges == 0) check(cyc - csFallCyc == E_SETUP, "R5 setup", cyc - csFallCyc, E_SETUP);
        else begin
          int h;
          h = cyc - lastEdgeCyc;
          if (h < minHalf) minHalf = h;
          if (h > maxHalf) maxHalf = h;
          check(h == (curLp ? E_HALF_L : E_HALF_N), "R3 half period", h, curLp ? E_HALF_L : E_HALF_N);
        end
        if (sclk) begin rises++; lastRiseCyc = cyc; end
        edges++;
        lastEdgeCyc = cyc;
      end
      if (!prevCs && csN) begin
        check(rises == 16, "R3 rising edges", rises, 16);
        check(cyc - lastRiseCyc == E_HOLD, "R5 hold", cyc - lastRiseCyc, E_HOLD);
        csRiseCyc = cyc; frameLen = cyc - csFallCyc; prevLp = curLp;
        lastMinHalf = minHalf; lastMaxHalf = maxHalf;
      end
      if (rspValid) begin
        rspCount++;
        if (expRsp.size() == 0) check(0, "R10 unexpected response", rspData, 0);
        else begin
          logic [15:0] e;
          e = expRsp.pop_front();
          check(rspData == e, "R9 response data", rspData, e);
        end
      end
      if (!csN && cmdReady) check(0, "R8 ready during frame", 1, 0);
    end
    prevCs = csN; prevSclk = sclk;
  end

  // ---------------- command driver ----------------
  logic [7:0] mirror [64];
  bit         lastRead = 0;
  logic [5:0] lastAddr = '0;

  initial for (int i = 0; i < 64; i++) mirror[i] = 8'(i) ^ 8'h5A;

  task automatic send(input bit wr, input logic [5:0] a, input logic [7:0] d);
    bit waited;
    @(negedge clk);
    cmdValid = 1; cmdWrite = wr; cmdAddr = a; cmdData = d;
    waited = 0;
    while (!cmdReady) begin waited = 1; @(negedge clk); end
    issueLp = (sampPeriod >= 8);
    issueWaited = waited;
    expDin.push_back({wr, 1'b0, a, wr ? d : 8'h00});
    if (lastRead) begin
      expRsp.push_back({lastAddr, 2'b01, mirror[lastAddr]});
      rspExpected++;
    end
    if (wr) mirror[a] = d;
    lastRead = !wr; lastAddr = a;
    @(negedge clk);
    cmdValid = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(csN == 1, "R1 csN", csN, 1);
    check(sclk == 1, "R1 sclk", sclk, 1);
    check(cmdReady == 1, "R1 cmdReady", cmdReady, 1);
    check(rspValid == 0, "R1 rspValid", rspValid, 0);

    // normal mode: writes then a sweep of every address
    sampPeriod = 8'd7;
    for (int i = 0; i < 8; i++) send(1, 6'(i * 9), 8'(8'hA0 + i * 17));
    for (int i = 0; i < 64; i++) send(0, 6'(i), 8'hFF);

    // low-power mode at the threshold
    sampPeriod = 8'd8;
    for (int i = 0; i < 4; i++) send(1, 6'(60 + i), 8'(8'h33 * (i + 1)));
    for (int i = 0; i < 8; i++) send(0, 6'(56 + i), 8'h00);
    sampPeriod = 8'd255;
    send(0, 6'd5, 8'h00);
    send(0, 6'd6, 8'h00);

    // normal mode at zero
    sampPeriod = 8'd0;
    send(0, 6'd7, 8'h00);
    send(1, 6'd1, 8'hC4);
    send(0, 6'd1, 8'h00);

    // R4: change the mode while a normal frame is in flight
    sampPeriod = 8'd7;
    send(0, 6'd2, 8'h00);
    sampPeriod = 8'd8;
    send(0, 6'd3, 8'h00);
    check(lastMaxHalf == E_HALF_N, "R4 in-flight frame kept normal", lastMaxHalf, E_HALF_N);
    check(lastMinHalf == E_HALF_N, "R4 in-flight frame kept normal min", lastMinHalf, E_HALF_N);
    send(1, 6'd4, 8'h11);
    check(lastMinHalf == E_HALF_L, "R4 low-power frame", lastMinHalf, E_HALF_L);

    // flush the final read with a write, then wait for it to end
    sampPeriod = 8'd7;
    send(0, 6'd9, 8'h00);
    send(1, 6'd10, 8'h77);
    wait (csN == 1);
    repeat (E_PER_L + 100) @(negedge clk);

    // R8: no frame without a request
    begin
      int f0;
      f0 = frames;
      repeat (2000) @(negedge clk);
      check(frames == f0, "R8 no spontaneous frame", frames, f0);
      check(cmdReady == 1, "R8 ready after limits", cmdReady, 1);
    end
    check(rspCount == rspExpected, "R10 response count", rspCount, rspExpected);
    check(expRsp.size() == 0, "R9 all responses seen", expRsp.size(), 0);
    check(expDin.size() == 0, "R2 all frames seen", expDin.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule